// File: doc/BRIEF.md
# Flash Row Erase Controller

This block sits on a processor's register bus and erases one 64-byte row (32 words) of on-chip program flash at a time. Software sets the mode bits in a control register, writes a two-byte unlock key to a separate key register, and then sets the start bit. The row is taken from the upper bits of a 22-bit table pointer. The six low bits pick a byte inside the row, so the erase ignores them. Single-word erase is not possible.

Once a start is accepted, the block holds the processor in a stall and drives an erase request with the latched row number to the flash array. An internal timer ends the erase after a fixed number of clock cycles. The timer length is a parameter, so about 2 ms can be set for silicon and a few cycles for simulation. At the end the stall drops and a one-cycle completion pulse is raised. Every erase needs its own fresh key sequence.

Top module: `flash_row_eraser`

## Requirements
- R1: After reset, stall_o, erase_req_o and done_o are 0, and the control register reads 0x00.
- R2: A key-register write (reg_addr_i=1) of 0x55, then one of 0xAA, then a control write (reg_addr_i=0) with start (bit 0), erase-select (bit 1) and write-enable (bit 2) set and config-select (bit 3) clear starts an erase. stall_o and erase_req_o go high from the next cycle.
- R3: Any key write that is not the expected next byte returns the unlock sequence to idle. After 0x55,0x12,0xAA or 0x55,0x55,0xAA, a start is ignored.
- R4: A start written with write-enable clear does nothing, and start reads back 0.
- R5: A start written with erase-select clear, or with config-select set, does nothing.
- R6: stall_o stays high for exactly ERASE_CYCLES cycles. done_o is high for exactly one cycle, the cycle after stall_o falls.
- R7: The control register reads {4'b0, config-select, write-enable, erase-select, busy}. Bit 0 is 1 during the erase and clears by itself when the erase ends.
- R8: Any control write with the start bit set uses up the unlock, whether or not it starts an erase. A later start needs a new 0x55/0xAA sequence.
- R9: erase_row_o equals ptr_i[21:6] sampled on the accepting write. Pointer bits [5:0], and pointer changes during the erase, have no effect on it.
- R10: Control writes made while an erase is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects control, 1 selects key |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| ptr_i | input | 22 | Table pointer |
| stall_o | output | 1 | Processor stall during the erase |
| erase_req_o | output | 1 | Erase strobe to the flash array |
| erase_row_o | output | 16 | Row number being erased |
| done_o | output | 1 | One-cycle pulse when the erase ends |

## Verification
The erase path is driven with a clean key-then-start sequence. It is also driven with the key bytes corrupted, repeated or followed by a second start, which tells unlock tracking apart from simple byte matching. Each mode bit is wrong in turn in at least one start. This shows that each of write-enable, erase-select and config-select gates the launch on its own. Pointers with different low-bit patterns, and pointer changes in the middle of an erase, separate row latching from pass-through of the pointer. A scoreboard flags any erase that was not expected, any wrong row and any wrong stall length.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_ERASE = 1;
  localparam int unsigned CTRL_WREN  = 2;
  localparam int unsigned CTRL_CFG   = 3;
  localparam logic        ADDR_CTRL  = 1'b0;
  localparam logic        ADDR_KEY   = 1'b1;
  localparam logic [7:0]  KEY_FIRST  = 8'h55;
  localparam logic [7:0]  KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_HALF  = 2'd1,
    UNL_ARMED = 2'd2
  } unlock_state_e;
endpackage

// File: rtl/fre_unlock.sv
module fre_unlock
  import flash_erase_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_data_i,
  input  logic       consume_i,
  output logic       armed_o
);
  unlock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (consume_i) begin
      state_d = UNL_IDLE;
    end else if (key_we_i) begin
      unique case (state_q)
        UNL_IDLE: state_d = (key_data_i == KEY_FIRST)  ? UNL_HALF  : UNL_IDLE;
        UNL_HALF: state_d = (key_data_i == KEY_SECOND) ? UNL_ARMED : UNL_IDLE;
        default:  state_d = UNL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UNL_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == UNL_ARMED);

  // R3
  arm_needs_second_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(key_we_i && key_data_i == KEY_SECOND));

  // R8
  consume_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !armed_o);
endmodule

// File: rtl/fre_timer.sv
module fre_timer #(
  parameter int unsigned ERASE_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LAST;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R6
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  // R6
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/flash_row_eraser.sv
module flash_row_eraser
  import flash_erase_pkg::*;
#(
  parameter int unsigned PTR_W        = 22,
  parameter int unsigned ROW_LSB      = 6,
  parameter int unsigned ERASE_CYCLES = 250000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic                     reg_addr_i,
  input  logic [7:0]               reg_wdata_i,
  output logic [7:0]               reg_rdata_o,
  input  logic [PTR_W-1:0]         ptr_i,
  output logic                     stall_o,
  output logic                     erase_req_o,
  output logic [PTR_W-ROW_LSB-1:0] erase_row_o,
  output logic                     done_o
);
  localparam int unsigned ROW_W = PTR_W - ROW_LSB;

  logic             busy, armed, ctrl_we, key_we, start_wr, mode_ok, launch;
  logic             cfg_q, wren_q, erase_q;
  logic [ROW_W-1:0] row_q;
  logic             unused_bits;

  assign ctrl_we  = reg_we_i && (reg_addr_i == ADDR_CTRL) && !busy;
  assign key_we   = reg_we_i && (reg_addr_i == ADDR_KEY) && !busy;
  assign start_wr = ctrl_we && reg_wdata_i[CTRL_START];
  assign mode_ok  = reg_wdata_i[CTRL_WREN] && reg_wdata_i[CTRL_ERASE] && !reg_wdata_i[CTRL_CFG];
  assign launch   = start_wr && mode_ok && armed;

  fre_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_we_i   (key_we),
    .key_data_i (reg_wdata_i),
    .consume_i  (start_wr),
    .armed_o    (armed)
  );

  fre_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (launch),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= 1'b0;
      wren_q  <= 1'b0;
      erase_q <= 1'b0;
      row_q   <= '0;
    end else begin
      if (ctrl_we) begin
        cfg_q   <= reg_wdata_i[CTRL_CFG];
        wren_q  <= reg_wdata_i[CTRL_WREN];
        erase_q <= reg_wdata_i[CTRL_ERASE];
      end
      if (launch) row_q <= ptr_i[PTR_W-1:ROW_LSB];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTRL) begin
      reg_rdata_o[CTRL_START] = busy;
      reg_rdata_o[CTRL_ERASE] = erase_q;
      reg_rdata_o[CTRL_WREN]  = wren_q;
      reg_rdata_o[CTRL_CFG]   = cfg_q;
    end
  end

  assign stall_o     = busy;
  assign erase_req_o = busy;
  assign erase_row_o = row_q;
  assign unused_bits = ^{ptr_i[ROW_LSB-1:0], reg_wdata_i[7:4]};

  // R2
  launch_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(armed && reg_we_i && reg_addr_i == ADDR_CTRL
      && reg_wdata_i[CTRL_START] && reg_wdata_i[CTRL_WREN]
      && reg_wdata_i[CTRL_ERASE] && !reg_wdata_i[CTRL_CFG]));

  // R9
  row_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(erase_row_o));

  // R10
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable({cfg_q, wren_q, erase_q}));
endmodule

// File: tb/tb_flash_row_eraser.sv
module tb_flash_row_eraser;
  localparam int unsigned CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [21:0] ptr = '0;
  logic        stall, ereq, done;
  logic [15:0] row;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_row_eraser #(.ERASE_CYCLES(CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ptr_i(ptr),
    .stall_o(stall), .erase_req_o(ereq), .erase_row_o(row), .done_o(done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 1'b0;
  endtask

  task automatic keys();
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
  endtask

  task automatic expect_erase(logic [21:0] p);
    ptr = p;
    exp_q.push_back(p[21:6]);
  endtask

  task automatic wait_idle();
    while (stall) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_ignored(string req);
    check({req, " stall"}, {31'd0, stall}, 32'd0);
    check({req, " start bit"}, {31'd0, rdata[0]}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares each observed erase against the scoreboard
  initial begin
    logic [15:0] exp_row;
    logic [15:0] row0;
    int          len;
    forever begin
      @(negedge clk);
      if (rst_n && stall) begin
        row0 = row;
        len = 0;
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2: unexpected erase row %0h, expected none", row);
          exp_row = row;
        end else begin
          exp_row = exp_q.pop_front();
        end
        check("R9 row", {16'd0, row}, {16'd0, exp_row});
        check("R2 erase_req", {31'd0, ereq}, 32'd1);
        while (stall) begin
          len++;
          check("R6 no early done", {31'd0, done}, 32'd0);
          @(negedge clk);
        end
        check("R6 stall length", len, CYC);
        check("R9 row held", {16'd0, row}, {16'd0, row0});
        check("R6 done pulse", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R6 done single", {31'd0, done}, 32'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 stall", {31'd0, stall}, 32'd0);
    check("R1 erase_req", {31'd0, ereq}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 ctrl", {24'd0, rdata}, 32'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl after release", {24'd0, rdata}, 32'h00);

    // R2 good erase; R7 readback; R10 writes ignored while busy
    wr(1'b0, 8'h06);
    keys();
    expect_erase(22'h2ABCFF);
    wr(1'b0, 8'h07);
    check("R2 stall high", {31'd0, stall}, 32'd1);
    check("R7 busy readback", {24'd0, rdata}, 32'h07);
    ptr = 22'h000000;
    wr(1'b0, 8'h00);
    check("R10 ctrl frozen", {24'd0, rdata}, 32'h07);
    wait_idle();
    check("R7 start self-clear", {24'd0, rdata}, 32'h06);

    // R9 same row, other low bits
    keys();
    expect_erase(22'h2ABC00);
    wr(1'b0, 8'h07);
    wait_idle();

    // R3 wrong middle byte
    keys_bad: begin
      wr(1'b1, 8'h55); wr(1'b1, 8'h12); wr(1'b1, 8'hAA);
      wr(1'b0, 8'h07);
      check_ignored("R3 bad byte");
      wr(1'b1, 8'h55); wr(1'b1, 8'h55); wr(1'b1, 8'hAA);
      wr(1'b0, 8'h07);
      check_ignored("R3 repeated 55");
      wr(1'b1, 8'hAA); wr(1'b1, 8'h55);
      wr(1'b0, 8'h07);
      check_ignored("R3 reversed");
    end

    // R4 write-enable clear
    keys();
    wr(1'b0, 8'h03);
    check_ignored("R4 wren clear");
    check("R4 readback", {24'd0, rdata}, 32'h02);

    // R5 erase-select clear, config-select set
    keys();
    wr(1'b0, 8'h05);
    check_ignored("R5 erase clear");
    keys();
    wr(1'b0, 8'h0F);
    check_ignored("R5 cfg set");

    // R8 unlock consumed by a good start
    keys();
    expect_erase(22'h1F0040);
    wr(1'b0, 8'h07);
    wait_idle();
    wr(1'b0, 8'h07);
    check_ignored("R8 reuse after erase");

    // R8 unlock consumed by a rejected start
    keys();
    wr(1'b0, 8'h05);
    wr(1'b0, 8'h07);
    check_ignored("R8 reuse after reject");

    // final good erase, different row
    keys();
    expect_erase(22'h00007F);
    wr(1'b0, 8'h07);
    wait_idle();

    check("R2 all expected erases seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule